// File: doc/BRIEF.md
# Parallel port handshake and interrupt control

This block holds the control-line and interrupt logic for one side of a two-port peripheral interface adapter. Control line 1 (CL1) is always an input. Its selected edge latches an interrupt flag. Control line 2 (CL2) is configured by a 6-bit control field. It can be an edge input with its own flag, a handshake output, a one-cycle strobe output, or a fixed level. An active-low interrupt request combines both flags with their enables.

The parameter `IS_PORT_B` picks the side. With 0, the handshake and strobe modes follow data-register reads. With 1, they follow data-register writes. The surrounding adapter supplies the control bits, one-cycle read and write strobes for this port's data register, and the two pins. It also reads the two flags back as the upper bits of its control register.

Top module: `pctl_side`

## Requirements
- R1: After synchronous reset, `cl2_out` is 1, `cl2_oe` is 0 (with cfg 0), both flags are 0 and `irq_n` is 1.
- R2: `cfg[1]` selects the active CL1 edge (0 falling, 1 rising). An active edge on `cl1_pin` raises `flag_cl1` after the third rising clock edge that follows the pin change. The inactive edge leaves the flag unchanged.
- R3: `flag_cl1` latches whatever the value of `cfg[0]`. `irq_n` is low while `flag_cl1` and `cfg[0]` are both 1, and `cfg[0]` = 0 removes that term.
- R4: With `cfg[5]` = 0, `cfg[4]` selects the active CL2 edge (0 falling, 1 rising), and that edge raises `flag_cl2` with the same latency as R2. `cfg[3]` = 1 lets `flag_cl2` pull `irq_n` low.
- R5: A cycle with `data_rd` high clears both flags at the next clock edge. A new active edge in that same cycle wins, and the flag stays 1.
- R6: While `cfg[5]` = 1, `flag_cl2` is held at 0, CL2 pin edges do not set it, and it does not drive `irq_n`.
- R7: `cl2_oe` equals `cfg[5]`. With `cfg[5:3]` = 110, `cl2_out` is 0. With 111, it is 1.
- R8: Port A (`IS_PORT_B`=0), `cfg[5:3]` = 100: a `data_rd` cycle drives `cl2_out` low from the next clock edge. An active CL1 edge drives it high, with the latency of R2. `data_wr` has no effect.
- R9: Port B (`IS_PORT_B`=1), `cfg[5:3]` = 100: a `data_wr` cycle drives `cl2_out` low from the next clock edge. An active CL1 edge drives it high. `data_rd` has no effect.
- R10: `cfg[5:3]` = 101: `cl2_out` is low for exactly the one clock cycle after each strobe cycle. The strobe is `data_rd` on port A and `data_wr` on port B. The other strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 6 | Control bits 5..0 of the port's control register |
| data_rd | input | 1 | One-cycle strobe: data register of this port read |
| data_wr | input | 1 | One-cycle strobe: data register of this port written |
| cl1_pin | input | 1 | Control line 1 pin (input only) |
| cl2_in | input | 1 | Control line 2 pin value, used in input mode |
| cl2_out | output | 1 | Control line 2 drive value |
| cl2_oe | output | 1 | Control line 2 output enable |
| flag_cl1 | output | 1 | CL1 interrupt flag (control register bit 7) |
| flag_cl2 | output | 1 | CL2 interrupt flag (control register bit 6) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block twice and feeds both copies the same stimulus. One copy has `IS_PORT_B` = 0 and the other has `IS_PORT_B` = 1. Expectations differ only where the side matters. This exposes the read-driven and write-driven handshake and strobe paths together, and shows that each side ignores the other side's strobe. The flag, edge-polarity, level and interrupt behaviour is checked on both copies at once.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int CFG_W = 6;

    typedef enum logic [2:0] {
        CL2_EDGE_IN,
        CL2_HANDSHAKE,
        CL2_STROBE,
        CL2_DRIVE_LOW,
        CL2_DRIVE_HIGH
    } cl2_mode_e;

    typedef struct packed {
        logic      cl1_ie;
        logic      cl1_rise;
        logic      cl2_ie;
        logic      cl2_rise;
        logic      cl2_drive;
        cl2_mode_e cl2_mode;
    } ctl_cfg_t;

    function automatic ctl_cfg_t decode_cfg(input logic [CFG_W-1:0] c);
        ctl_cfg_t d;
        d.cl1_ie    = c[0];
        d.cl1_rise  = c[1];
        d.cl2_ie    = c[3];
        d.cl2_rise  = c[4];
        d.cl2_drive = c[5];
        case (c[5:3])
            3'b100:  d.cl2_mode = CL2_HANDSHAKE;
            3'b101:  d.cl2_mode = CL2_STROBE;
            3'b110:  d.cl2_mode = CL2_DRIVE_LOW;
            3'b111:  d.cl2_mode = CL2_DRIVE_HIGH;
            default: d.cl2_mode = CL2_EDGE_IN;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pctl_edge_det.sv
module pctl_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic act
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[LAST-1:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[LAST];
    end

    always_comb begin
        if (rise_sel) act = sync_q[LAST] & ~prev_q;
        else          act = ~sync_q[LAST] & prev_q;
    end

    // R2
    edge_changes_level_chk: assert property (@(posedge clk) disable iff (rst)
        act |=> (prev_q == rise_sel || $past(rise_sel) != rise_sel));

endmodule

// File: rtl/pctl_flag.sv
module pctl_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic hold_zero,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (hold_zero) q <= 1'b0;
        else if (set)       q <= 1'b1;
        else if (clr)       q <= 1'b0;
    end

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (set && !hold_zero) |=> q);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);

    // R6
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hold_zero |=> !q);

endmodule

// File: rtl/pctl_cl2_drive.sv
module pctl_cl2_drive
    import pctl_pkg::*;
#(
    parameter bit IS_PORT_B = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  cl2_mode_e mode,
    input  logic      data_rd,
    input  logic      data_wr,
    input  logic      cl1_act,
    output logic      cl2_out
);
    logic strobe;
    logic hs_q;
    logic pulse_q;

    generate
        if (IS_PORT_B) begin : g_write_side
            assign strobe = data_wr;
        end else begin : g_read_side
            assign strobe = data_rd;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          hs_q <= 1'b1;
        else if (cl1_act) hs_q <= 1'b1;
        else if (strobe)  hs_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= strobe;
    end

    always_comb begin
        case (mode)
            CL2_HANDSHAKE:  cl2_out = hs_q;
            CL2_STROBE:     cl2_out = ~pulse_q;
            CL2_DRIVE_LOW:  cl2_out = 1'b0;
            default:        cl2_out = 1'b1;
        endcase
    end

    // R8 R9
    hs_set_chk: assert property (@(posedge clk) disable iff (rst)
        cl1_act |=> hs_q);

    // R8 R9
    hs_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !cl1_act) |=> !hs_q);

    // R10
    strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && mode == CL2_STROBE) |=> (mode != CL2_STROBE || !cl2_out));

endmodule

// File: rtl/pctl_side.sv
module pctl_side
    import pctl_pkg::*;
#(
    parameter bit IS_PORT_B   = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic             cl1_pin,
    input  logic             cl2_in,
    output logic             cl2_out,
    output logic             cl2_oe,
    output logic             flag_cl1,
    output logic             flag_cl2,
    output logic             irq_n
);
    ctl_cfg_t dcfg;
    logic     cl1_act;
    logic     cl2_act;
    logic     drv_val;

    assign dcfg = decode_cfg(cfg);

    pctl_edge_det #(.STAGES(SYNC_STAGES)) u_cl1_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (cl1_pin),
        .rise_sel (dcfg.cl1_rise),
        .act      (cl1_act)
    );

    pctl_edge_det #(.STAGES(SYNC_STAGES)) u_cl2_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (cl2_in),
        .rise_sel (dcfg.cl2_rise),
        .act      (cl2_act)
    );

    pctl_flag u_flag_cl1 (
        .clk       (clk),
        .rst       (rst),
        .set       (cl1_act),
        .clr       (data_rd),
        .hold_zero (1'b0),
        .q         (flag_cl1)
    );

    pctl_flag u_flag_cl2 (
        .clk       (clk),
        .rst       (rst),
        .set       (cl2_act),
        .clr       (data_rd),
        .hold_zero (dcfg.cl2_drive),
        .q         (flag_cl2)
    );

    pctl_cl2_drive #(.IS_PORT_B(IS_PORT_B)) u_cl2_drive (
        .clk     (clk),
        .rst     (rst),
        .mode    (dcfg.cl2_mode),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .cl1_act (cl1_act),
        .cl2_out (drv_val)
    );

    assign cl2_oe  = dcfg.cl2_drive;
    assign cl2_out = dcfg.cl2_drive ? drv_val : 1'b1;
    assign irq_n   = ~((flag_cl1 & dcfg.cl1_ie) |
                       (flag_cl2 & dcfg.cl2_ie & ~dcfg.cl2_drive));

    // R3
    irq_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_cl1 && cfg[0]) |-> !irq_n);

    // R3 R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg[0] && (cfg[5] || !cfg[3])) |-> irq_n);

endmodule

// File: tb/pctl_side_tb_top.sv
module pctl_side_tb_top;

    localparam int A_CL2 = 0, A_F1 = 1, A_F2 = 2, A_IRQ = 3, A_OE = 4;
    localparam int B_CL2 = 5, B_F1 = 6, B_F2 = 7, B_IRQ = 8, B_OE = 9;

    typedef struct {
        int    sig;
        logic  exp;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cfg = '0;
    logic       data_rd = 1'b0;
    logic       data_wr = 1'b0;
    logic       cl1_pin = 1'b1;
    logic       cl2_in  = 1'b1;

    logic a_cl2, a_oe, a_f1, a_f2, a_irq;
    logic b_cl2, b_oe, b_f1, b_f2, b_irq;

    item_t q[$];
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #5 clk = ~clk;

    pctl_side #(.IS_PORT_B(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cfg(cfg), .data_rd(data_rd), .data_wr(data_wr),
        .cl1_pin(cl1_pin), .cl2_in(cl2_in), .cl2_out(a_cl2), .cl2_oe(a_oe),
        .flag_cl1(a_f1), .flag_cl2(a_f2), .irq_n(a_irq)
    );

    pctl_side #(.IS_PORT_B(1'b1)) dut_b_i (
        .clk(clk), .rst(rst), .cfg(cfg), .data_rd(data_rd), .data_wr(data_wr),
        .cl1_pin(cl1_pin), .cl2_in(cl2_in), .cl2_out(b_cl2), .cl2_oe(b_oe),
        .flag_cl1(b_f1), .flag_cl2(b_f2), .irq_n(b_irq)
    );

    function automatic logic sample(input int sig);
        case (sig)
            A_CL2:   return a_cl2;
            A_F1:    return a_f1;
            A_F2:    return a_f2;
            A_IRQ:   return a_irq;
            A_OE:    return a_oe;
            B_CL2:   return b_cl2;
            B_F1:    return b_f1;
            B_F2:    return b_f2;
            B_IRQ:   return b_irq;
            default: return b_oe;
        endcase
    endfunction

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic  act;
            it  = q.pop_front();
            act = sample(it.sig);
            n_vec++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s signal %0d actual %b expected %b", it.tag, it.sig, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_val(input int sig, input logic exp, input string tag);
        item_t it;
        it.sig = sig;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // pin change, then two synchronizer edges: the next edge latches it
    task automatic move_cl1(input logic v);
        cl1_pin = v;
        tick();
        tick();
    endtask

    task automatic move_cl2(input logic v);
        cl2_in = v;
        tick();
        tick();
    endtask

    task automatic strobe_rd();
        data_rd = 1'b1;
        tick();
        data_rd = 1'b0;
    endtask

    task automatic strobe_wr();
        data_wr = 1'b1;
        tick();
        data_wr = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        expect_val(A_CL2, 1'b1, "R1"); expect_val(A_OE, 1'b0, "R1");
        expect_val(A_F1, 1'b0, "R1");  expect_val(A_F2, 1'b0, "R1");
        expect_val(A_IRQ, 1'b1, "R1"); expect_val(B_CL2, 1'b1, "R1");
        expect_val(B_IRQ, 1'b1, "R1");
        settle();

        // R2 falling edge on CL1, cfg[1]=0
        cfg = 6'b000000;
        cl1_pin = 1'b0;
        tick(); tick();
        expect_val(A_F1, 1'b0, "R2"); settle();
        tick();
        expect_val(A_F1, 1'b1, "R2"); expect_val(B_F1, 1'b1, "R2");
        // R3 flag set with interrupt disabled
        expect_val(A_IRQ, 1'b1, "R3");
        settle();
        cfg = 6'b000001;
        #1;
        expect_val(A_IRQ, 1'b0, "R3"); expect_val(B_IRQ, 1'b0, "R3");
        settle();

        // R5 read clears the flag
        strobe_rd();
        expect_val(A_F1, 1'b0, "R5"); expect_val(A_IRQ, 1'b1, "R5");
        settle();

        // R2 rising edge is inactive while cfg[1]=0
        move_cl1(1'b1); tick();
        expect_val(A_F1, 1'b0, "R2"); settle();
        cfg = 6'b000011;
        move_cl1(1'b0); tick();
        move_cl1(1'b1); tick();
        expect_val(A_F1, 1'b1, "R2"); expect_val(A_IRQ, 1'b0, "R3");
        settle();

        // R5 clear and new edge in the same cycle: set wins
        move_cl1(1'b0); tick();
        move_cl1(1'b1);
        strobe_rd();
        expect_val(A_F1, 1'b1, "R5"); expect_val(B_F1, 1'b1, "R5");
        settle();
        strobe_rd();
        expect_val(A_F1, 1'b0, "R5");
        settle();

        // R4 CL2 input, rising edge active, interrupt enabled
        cfg = 6'b011000;
        move_cl2(1'b0); tick();
        expect_val(A_F2, 1'b0, "R4"); settle();
        move_cl2(1'b1); tick();
        expect_val(A_F2, 1'b1, "R4"); expect_val(A_IRQ, 1'b0, "R4");
        expect_val(A_OE, 1'b0, "R4");
        settle();
        cfg = 6'b010000;
        #1;
        expect_val(A_IRQ, 1'b1, "R4"); expect_val(A_F2, 1'b1, "R4");
        settle();

        // R6 R7 manual high forces flag_cl2 low
        cfg = 6'b111000;
        tick();
        expect_val(A_F2, 1'b0, "R6"); expect_val(A_IRQ, 1'b1, "R6");
        expect_val(A_CL2, 1'b1, "R7"); expect_val(A_OE, 1'b1, "R7");
        expect_val(B_CL2, 1'b1, "R7");
        settle();
        move_cl2(1'b0); tick();
        move_cl2(1'b1); tick();
        expect_val(A_F2, 1'b0, "R6"); expect_val(B_F2, 1'b0, "R6");
        settle();
        cfg = 6'b110000;
        #1;
        expect_val(A_CL2, 1'b0, "R7"); expect_val(B_CL2, 1'b0, "R7");
        settle();

        // R8 R9 handshake, CL1 rising edge active
        cfg = 6'b100010;
        strobe_rd();
        expect_val(A_CL2, 1'b0, "R8"); expect_val(B_CL2, 1'b1, "R9");
        settle();
        strobe_wr();
        expect_val(B_CL2, 1'b0, "R9"); expect_val(A_CL2, 1'b0, "R8");
        settle();
        move_cl1(1'b0); tick();
        expect_val(A_CL2, 1'b0, "R8"); expect_val(B_CL2, 1'b0, "R9");
        settle();
        move_cl1(1'b1);
        expect_val(A_CL2, 1'b0, "R8"); settle();
        tick();
        expect_val(A_CL2, 1'b1, "R8"); expect_val(B_CL2, 1'b1, "R9");
        settle();

        // R10 one-cycle strobe output
        cfg = 6'b101000;
        strobe_rd();
        expect_val(A_CL2, 1'b0, "R10"); expect_val(B_CL2, 1'b1, "R10");
        settle();
        tick();
        expect_val(A_CL2, 1'b1, "R10"); settle();
        strobe_wr();
        expect_val(B_CL2, 1'b0, "R10"); expect_val(A_CL2, 1'b1, "R10");
        settle();
        tick();
        expect_val(B_CL2, 1'b1, "R10"); settle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule